// File: doc/BRIEF.md
# Oscillator-Gated Reset Controller

This block produces the internal reset of a real-time clock device and holds it for as long as the slow 32.768 kHz crystal oscillator is judged stopped. The reset does not last a fixed number of cycles. A fast sampling clock watches the oscillator input through a synchroniser. Rising edges must keep arriving within a timeout. A run of consecutive edges that each arrive inside that timeout marks the oscillator as running, and the reset is then released.

Each internal reset sets a sticky stop flag. While the reset lasts, the power-on control bits are forced to their defaults: clock output on, 24-hour mode, battery switch-over on and battery-low detection on. Board test can skip the long crystal start-up by engaging an override, which releases the reset with no oscillation present. The override can be engaged only while a permit bit is set. Writing 0 to the permit bit disarms the override and clears it. All the control bits are read and written through one 7-bit register word.

Top module: `osc_reset_ctrl`

## Requirements
- R1: `rst_int_n` is 0 in the cycle after one in which the oscillator is judged stopped and the override is inactive. It is 1 in the cycle after one in which the oscillator is running or the override is active.
- R2: `osc_in` passes through a two-flop synchroniser before edge detection. The oscillator is judged stopped from power-on. It is also judged stopped once TIMEOUT_CYC sampling cycles pass with no synchronised rising edge. It is judged running after RUN_EDGES consecutive rising edges, each arriving within TIMEOUT_CYC cycles of the one before.
- R3: The stop flag (register bit 0) becomes 1 after every cycle of internal reset and is sticky. A write with bit 0 = 0 clears it only while the internal reset is released. A write with bit 0 = 1 leaves it unchanged.
- R4: While the internal reset is asserted, the default bits are held at 1 and writes to them are ignored: clock-out enable (bit 3), 24-hour mode (bit 4), battery switch-over enable (bit 5) and battery-low detect enable (bit 6). While the reset is released, a write loads them from the write word.
- R5: While `por_n` is 0, every clock edge forces the internal reset, sets the stop flag, sets the permit bit, clears the override and restores all defaults, whatever the oscillator is doing. This gives `rd_data` = 7'h7B.
- R6: A write with the permit bit (bit 1) = 0 clears both the permit bit and the override-active bit (bit 2). A write with bits 1 and 2 both at 1 engages the override if the permit bit was already 1. A write with bit 2 = 0 clears the override.
- R7: An `ovr_req` pulse engages the override when the permit bit is 1 and no write happens in that cycle. It is ignored when the permit bit is 0. An engaged override releases the reset with the oscillator stopped.
- R8: `rd_data` shows the register word with these bits: bit 0 stop flag, 1 permit, 2 override active, 3 clock-out, 4 24-hour, 5 battery switch-over, 6 battery-low detect. The dedicated outputs carry the same values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| por_n | input | 1 | Raw power-on indication, active low, sampled synchronously |
| osc_in | input | 1 | 32.768 kHz oscillator signal, asynchronous |
| ovr_req | input | 1 | One-cycle request to engage the override |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 7 | Register write word |
| rst_int_n | output | 1 | Internal reset, active low |
| osc_stop_flag | output | 1 | Sticky oscillator-stop flag |
| clkout_en | output | 1 | Clock output enable |
| mode_24h | output | 1 | 24-hour mode select |
| batsw_en | output | 1 | Battery switch-over enable |
| batlow_en | output | 1 | Battery-low detection enable |
| ovr_permit | output | 1 | Override permit bit |
| ovr_active | output | 1 | Override active status |
| rd_data | output | 7 | Register read word |

## Verification
Several rules are checked by assertions on every cycle: the reset follows the oscillator and override state, the flag is set and the defaults are forced during reset, a permit write of 0 clears the override, a request without permit has no effect, and the monitor drops to stopped on timeout. Other behaviour shows only in the bench's scenarios. This covers the exact count of edges needed to release reset, the real delay between the last edge and the stop, writes ignored during reset, a write of 1 leaving the stop flag unchanged, and override-engaged test with no oscillation. Random write and request sequences are compared with a bench model of the register word.

// File: rtl/osc_rst_pkg.sv
// Shared field positions and types for the oscillator-gated reset controller.
// Assumes a 7-bit control word. The bit positions are visible to software.
package osc_rst_pkg;
    localparam int CTRL_W     = 7;
    localparam int OSF_BIT    = 0;
    localparam int PERMIT_BIT = 1;
    localparam int OVR_BIT    = 2;
    localparam int DFLT_LSB   = 3;
    localparam int DFLT_W     = 4;

    // Power-on default bits, MSB first to match the word bits 6..3
    typedef struct packed {
        logic batlow;
        logic batsw;
        logic mode24;
        logic clkout;
    } dflt_t;
endpackage

// File: rtl/osc_edge_sync.sv
// Synchroniser and rising-edge detector for the slow oscillator input.
// Assumes osc_in is asynchronous to clk. STAGES flops resolve metastability,
// and one more flop gives the previous sample for edge detection.
module osc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic osc_in,
    output logic rise
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    // Shift the raw input through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!por_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[PIPE_W-2:0], osc_in};
        end
    end

    // Rising edge: synchronised level high, previous sample low
    always_comb begin
        rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end
endmodule

// File: rtl/osc_activity_mon.sv
// Judges whether the oscillator runs, from the spacing of its rising edges.
// Assumes TIMEOUT_CYC >= 2 and RUN_EDGES >= 1. Starts as stopped after power-on.
module osc_activity_mon #(
    parameter int TIMEOUT_CYC = 4096,
    parameter int RUN_EDGES   = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic rise,
    output logic running
);
    localparam int GAP_W = $clog2(TIMEOUT_CYC + 1);
    localparam int RUN_W = $clog2(RUN_EDGES + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(TIMEOUT_CYC - 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_EDGES - 1);

    logic [GAP_W-1:0] gap_q;
    logic [RUN_W-1:0] good_q;
    logic             running_q;

    // Count cycles since the last edge, saturating at the timeout
    always_ff @(posedge clk) begin
        if (!por_n) begin
            gap_q <= '0;
        end else if (rise) begin
            gap_q <= '0;
        end else if (gap_q != GAP_LAST) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Count consecutive timely edges and update the running state
    always_ff @(posedge clk) begin
        if (!por_n) begin
            good_q    <= '0;
            running_q <= 1'b0;
        end else if (rise) begin
            if (!running_q) begin
                if (good_q == RUN_LAST) begin
                    running_q <= 1'b1;
                    good_q    <= '0;
                end else begin
                    good_q <= good_q + 1'b1;
                end
            end
        end else if (gap_q == GAP_LAST) begin
            running_q <= 1'b0;
            good_q    <= '0;
        end
    end

    assign running = running_q;

    AST_STOP_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!por_n)
        (gap_q == GAP_LAST && !rise) |=> !running_q); // R2
    AST_NO_RUN_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!por_n)
        (!running_q && !rise) |=> !running_q); // R2
endmodule

// File: rtl/osc_ctrl_regs.sv
// Control word: sticky stop flag, override permit and status, default bits.
// Assumes rst_active is the registered internal reset. Override fields stay
// writable during reset, because board test engages the override then.
module osc_ctrl_regs
    import osc_rst_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_active,
    input  logic              ovr_req,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              osf,
    output logic              permit,
    output logic              ovr,
    output dflt_t             dflt
);
    logic  osf_q;
    logic  permit_q;
    logic  ovr_q;
    dflt_t dflt_q;

    // Stop flag: set by any reset, cleared by writing 0 outside reset
    always_ff @(posedge clk) begin
        if (!por_n) begin
            osf_q <= 1'b1;
        end else if (rst_active) begin
            osf_q <= 1'b1;
        end else if (wr_en && !wr_data[OSF_BIT]) begin
            osf_q <= 1'b0;
        end
    end

    // Default bits: forced during reset, loaded by writes otherwise
    always_ff @(posedge clk) begin
        if (!por_n) begin
            dflt_q <= '1;
        end else if (rst_active) begin
            dflt_q <= '1;
        end else if (wr_en) begin
            dflt_q <= dflt_t'(wr_data[DFLT_LSB +: DFLT_W]);
        end
    end

    // Permit bit: set at power-on, follows register writes
    always_ff @(posedge clk) begin
        if (!por_n) begin
            permit_q <= 1'b1;
        end else if (wr_en) begin
            permit_q <= wr_data[PERMIT_BIT];
        end
    end

    // Override status: engaged by write or request only while permitted
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ovr_q <= 1'b0;
        end else if (wr_en) begin
            if (!wr_data[PERMIT_BIT] || !wr_data[OVR_BIT]) begin
                ovr_q <= 1'b0;
            end else if (permit_q) begin
                ovr_q <= 1'b1;
            end
        end else if (ovr_req && permit_q) begin
            ovr_q <= 1'b1;
        end
    end

    assign osf    = osf_q;
    assign permit = permit_q;
    assign ovr    = ovr_q;
    assign dflt   = dflt_q;

    AST_OSF_SET_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        rst_active |=> osf_q); // R3
    AST_DEFAULTS_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        rst_active |=> (dflt_q == '1)); // R4
    AST_PERMIT_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !wr_data[PERMIT_BIT]) |=> (!permit_q && !ovr_q)); // R6
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
        (ovr_req && !wr_en && !permit_q && !ovr_q) |=> !ovr_q); // R7
endmodule

// File: rtl/osc_reset_ctrl.sv
// Top: internal reset gated by oscillator activity, with a test override.
// Assumes por_n is the raw power-on indication, sampled synchronously. The
// internal reset is registered, so its release is synchronous to clk.
module osc_reset_ctrl
    import osc_rst_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096,
    parameter int RUN_EDGES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              osc_in,
    input  logic              ovr_req,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              rst_int_n,
    output logic              osc_stop_flag,
    output logic              clkout_en,
    output logic              mode_24h,
    output logic              batsw_en,
    output logic              batlow_en,
    output logic              ovr_permit,
    output logic              ovr_active,
    output logic [CTRL_W-1:0] rd_data
);
    logic  osc_rise;
    logic  osc_running;
    logic  rst_q;
    logic  osf;
    logic  permit;
    logic  ovr;
    dflt_t dflt;

    osc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .por_n  (por_n),
        .osc_in (osc_in),
        .rise   (osc_rise)
    );

    osc_activity_mon #(.TIMEOUT_CYC(TIMEOUT_CYC), .RUN_EDGES(RUN_EDGES)) i_mon (
        .clk     (clk),
        .por_n   (por_n),
        .rise    (osc_rise),
        .running (osc_running)
    );

    osc_ctrl_regs i_regs (
        .clk        (clk),
        .por_n      (por_n),
        .rst_active (~rst_q),
        .ovr_req    (ovr_req),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .osf        (osf),
        .permit     (permit),
        .ovr        (ovr),
        .dflt       (dflt)
    );

    // Internal reset: released while the oscillator runs or the override holds
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rst_q <= 1'b0;
        end else begin
            rst_q <= osc_running | ovr;
        end
    end

    // Drive the dedicated outputs and assemble the read word
    always_comb begin
        rst_int_n     = rst_q;
        osc_stop_flag = osf;
        ovr_permit    = permit;
        ovr_active    = ovr;
        clkout_en     = dflt.clkout;
        mode_24h      = dflt.mode24;
        batsw_en      = dflt.batsw;
        batlow_en     = dflt.batlow;
        rd_data                       = '0;
        rd_data[OSF_BIT]              = osf;
        rd_data[PERMIT_BIT]           = permit;
        rd_data[OVR_BIT]              = ovr;
        rd_data[DFLT_LSB +: DFLT_W]   = dflt;
    end

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!por_n)
        (!osc_running && !ovr) |=> !rst_int_n); // R1
    AST_RELEASE_WHEN_OK: assert property (@(posedge clk) disable iff (!por_n)
        (osc_running || ovr) |=> rst_int_n); // R1
endmodule

// File: tb/test_osc_reset_ctrl.sv
module test_osc_reset_ctrl;
    localparam int TMO = 64;
    localparam int RUNE = 3;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       osc_in = 1'b0;
    logic       ovr_req = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic       rst_int_n, osc_stop_flag, clkout_en, mode_24h, batsw_en, batlow_en;
    logic       ovr_permit, ovr_active;
    logic [6:0] rd_data;

    int checks = 0;
    int failures = 0;
    logic [6:0] exp_word;

    always #5 clk = ~clk;

    osc_reset_ctrl #(.TIMEOUT_CYC(TMO), .RUN_EDGES(RUNE)) i_osc_reset_ctrl (
        .clk(clk), .por_n(por_n), .osc_in(osc_in), .ovr_req(ovr_req),
        .wr_en(wr_en), .wr_data(wr_data), .rst_int_n(rst_int_n),
        .osc_stop_flag(osc_stop_flag), .clkout_en(clkout_en), .mode_24h(mode_24h),
        .batsw_en(batsw_en), .batlow_en(batlow_en), .ovr_permit(ovr_permit),
        .ovr_active(ovr_active), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the register word outside reset (R3, R4, R6, R7)
    function automatic logic [6:0] model(input logic [6:0] q, input logic wr,
                                         input logic [6:0] d, input logic req);
        logic [6:0] r;
        r = q;
        if (wr) begin
            r[0]   = q[0] & d[0];
            r[6:3] = d[6:3];
            r[1]   = d[1];
            if (!d[1] || !d[2]) r[2] = 1'b0;
            else if (q[1])      r[2] = 1'b1;
        end else if (req && q[1]) begin
            r[2] = 1'b1;
        end
        return r;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One oscillator period of 20 sampling cycles, ending 19 cycles after the rise
    task automatic pulses(input int n);
        repeat (n) begin
            @(negedge clk) osc_in = 1'b1;
            cycles(10);
            osc_in = 1'b0;
            cycles(9);
        end
    endtask

    task automatic write(input logic [6:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic request();
        @(negedge clk) ovr_req = 1'b1;
        @(negedge clk) ovr_req = 1'b0;
    endtask

    task automatic power_on();
        @(negedge clk) por_n = 1'b0;
        cycles(3);
        check("R5 reset word", rd_data, 7'h7B);
        check("R5 rst_int_n", rst_int_n, 0);
        por_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        power_on();
        // R2: no oscillation keeps reset on
        cycles(200);
        check("R2 stopped from power-on", rst_int_n, 0);
        check("R8 outputs", {batlow_en, batsw_en, mode_24h, clkout_en, ovr_active, ovr_permit, osc_stop_flag}, 7'h7B);
        // R3/R4: writes ignored for flag and defaults during reset
        write(7'h02);
        check("R3 R4 writes ignored in reset", rd_data, 7'h7B);
        // R2: one edge short of the run count
        pulses(RUNE - 1);
        check("R2 short run keeps reset", rst_int_n, 0);
        pulses(1);
        check("R1 release after run count", rst_int_n, 1);
        // R3: clear flag, then a write of 1 leaves it clear
        write(7'h7A);
        check("R3 flag cleared", rd_data, 7'h7A);
        write(7'h03);
        check("R3 R4 write 1 keeps flag clear", rd_data, 7'h02);
        write(7'h7A);
        // R2: timeout timing after the last edge
        pulses(1);
        cycles(31);
        check("R2 within timeout still running", rst_int_n, 1);
        cycles(30);
        check("R1 reset after timeout", rst_int_n, 0);
        cycles(2);
        check("R3 R4 flag and defaults after reset", rd_data, 7'h7B);
        // R7: override releases reset with no oscillation
        request();
        cycles(3);
        check("R7 override engaged", rd_data, 7'h7F);
        check("R7 override releases reset", rst_int_n, 1);
        // R6: permit write of 0 clears the override
        write(7'h79);
        check("R6 permit zero clears override", rd_data, 7'h79);
        cycles(3);
        check("R1 reset back without override", rst_int_n, 0);
        // R7: request without permit ignored
        request();
        cycles(3);
        check("R7 request ignored", rd_data[2:1], 2'b00);
        check("R7 reset stays", rst_int_n, 0);
        // R6: re-permit, then engage through the register
        write(7'h03);
        check("R6 permit set", rd_data, 7'h7B);
        write(7'h07);
        cycles(3);
        check("R6 write engages override", rd_data, 7'h7F);
        check("R6 override releases reset", rst_int_n, 1);
        // R5: power-on again, then random writes and requests while running
        power_on();
        pulses(RUNE);
        check("R1 running after power-on", rst_int_n, 1);
        exp_word = 7'h7B;
        for (int i = 0; i < 200; i++) begin
            logic [6:0] d;
            logic       do_wr;
            pulses(1);
            d = 7'($urandom);
            do_wr = ($urandom % 3) != 0;
            if (do_wr) begin
                write(d);
                exp_word = model(exp_word, 1'b1, d, 1'b0);
            end else begin
                request();
                exp_word = model(exp_word, 1'b0, d, 1'b1);
            end
            check("R6 R7 R8 random word", rd_data, exp_word);
            check("R1 stays released", rst_int_n, 1);
        end
        // R5: power-on while running restores everything
        power_on();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule